// File: doc/BRIEF.md
# Write Data-Phase Protocol Checker

This block watches the data phase of a pipelined processor system bus and reports protocol violations made by the agent that drives write data. It applies to ordinary writes and to implicit writebacks alike, because both share the same request queue and data-phase path. Every accepted write request carries a 2-bit length code. The block keeps these codes in order in a small queue. When the target signals ready and no data phase is open, the oldest code becomes the expected beat count of the new data phase.

While a phase is open, the block counts the data-ready beats. It treats a beat with data-busy low as the last beat of the phase. A separate timer for each of the two busy signals (data-busy, and a sideband snoop-busy) watches whether the agent releases data-ready in time after that busy signal falls. Each violation appears as a one-cycle pulse, one clock after the offending cycle. An external status register is expected to latch the pulses, so the block keeps no sticky error state.

Top module: `wr_data_phase_chk`

## Requirements
- R1: Length code 0, 1, 2 and 3 mean 0, 1, 2 and 4 beats. A request is queued on each cycle with `req_valid_i` high. Queued requests are consumed in arrival order, one per `trdy_i` cycle taken. A nonzero expectation opens a data phase from the next cycle on.
- R2: A beat is `drdy_i` high while a phase is open. The last beat is one with `dbsy_i` low, and it closes the phase. If the beats counted, including the last one, differ from the expected count, `err_len_o` pulses in the next cycle. This covers both too few and too many beats.
- R3: `drdy_i` high while no data phase is open is unsolicited data, and `err_wdata_o` pulses in the next cycle.
- R4: A taken `trdy_i` for a zero-length request opens no phase, so any `drdy_i` for it raises `err_wdata_o`.
- R5: If `drdy_i` is high on the cycle `dbsy_i` falls and stays high through the next cycle, `err_hold_o` pulses in the cycle after that.
- R6: If `drdy_i` is high on the cycle `sbsy_i` falls and stays high through the two following cycles, `err_hold_o` pulses in the cycle after the second one. If `drdy_i` drops before then, there is no error.
- R7: Each error output is a single-cycle pulse per event. `err_len_o` is never high on two consecutive cycles.
- R8: During and after reset all outputs are low. No error is reported until the first request has been seen on `req_valid_i`.
- R9: `trdy_i` is ignored while a data phase is open or while the queue is empty. In that case no request is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A write or implicit-writeback request is accepted this cycle |
| req_len_i | input | 2 | Length code of that request |
| trdy_i | input | 1 | Target ready for the oldest queued write |
| drdy_i | input | 1 | Data-ready strobe from the writing agent |
| dbsy_i | input | 1 | Data-busy strobe, high on all beats but the last |
| sbsy_i | input | 1 | Sideband snoop-busy |
| err_len_o | output | 1 | Pulse: beat count differs from the length code |
| err_wdata_o | output | 1 | Pulse: data-ready with no ready data phase |
| err_hold_o | output | 1 | Pulse: data-ready held past a busy release window |

## Verification
Every error output is registered. A violation seen at one rising edge therefore shows on its output after the next edge. The two hold errors come one clock after the window expires: two edges after the data-busy fall, three edges after the snoop-busy fall. The bench's reference model evaluates the same edge from the inputs it drove and stores the result as the value expected after the following edge. It compares all three outputs at every falling edge. Directed scenarios also total the pulses of each output over the scenario, with idle cycles appended, so that a late, missing or stretched pulse changes a total.

// File: rtl/wdpc_pkg.sv
package wdpc_pkg;

  localparam int LEN_CODE_W = 2;
  localparam int BEATS_W    = 3;

  typedef logic [LEN_CODE_W-1:0] len_code_t;
  typedef logic [BEATS_W-1:0]    beats_t;

  // Map a request length code to the number of data beats it promises.
  function automatic beats_t beats_of(input len_code_t code);
    case (code)
      2'd0:    beats_of = 3'd0;
      2'd1:    beats_of = 3'd1;
      2'd2:    beats_of = 3'd2;
      default: beats_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/wdpc_len_fifo.sv
module wdpc_len_fifo #(
  parameter int DEPTH = 4
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                push_i,
  input  wdpc_pkg::len_code_t push_code_i,
  input  logic                pop_i,
  output wdpc_pkg::len_code_t head_code_o,
  output logic                empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wdpc_pkg::len_code_t    store_q [DEPTH];
  logic [PTR_W-1:0]       wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]       fill_q;

  logic push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    wrap_inc = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o     = (fill_q == '0);
  assign push_ok     = push_i && (fill_q != CNT_W'(DEPTH));
  assign pop_ok      = pop_i && !empty_o;
  assign head_code_o = store_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) store_q[wr_ptr_q] <= push_code_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wrap_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= wrap_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

endmodule

// File: rtl/wdpc_phase_track.sv
module wdpc_phase_track #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             trdy_i,
  input  logic             drdy_i,
  input  logic             dbsy_i,
  input  logic             q_empty_i,
  input  wdpc_pkg::beats_t head_beats_i,
  output logic             pop_o,
  output logic             phase_open_o,
  output logic             len_evt_o,
  output logic             wd_evt_o
);
  logic                 open_q;
  wdpc_pkg::beats_t     exp_q;
  logic [CNT_W-1:0]     cnt_q;

  logic             beat, last_beat;
  logic [CNT_W-1:0] cnt_inc;

  // Saturating beat counter step, so an overlong burst never wraps to a match.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    sat_inc = (c == {CNT_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  assign beat         = drdy_i && open_q;
  assign last_beat    = beat && !dbsy_i;
  assign cnt_inc      = sat_inc(cnt_q);
  assign pop_o        = trdy_i && !open_q && !q_empty_i;
  assign phase_open_o = open_q;
  assign len_evt_o    = last_beat && (int'(cnt_inc) != int'(exp_q));
  assign wd_evt_o     = drdy_i && !open_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      open_q <= 1'b0;
      exp_q  <= '0;
      cnt_q  <= '0;
    end else if (pop_o) begin
      exp_q  <= head_beats_i;
      cnt_q  <= '0;
      open_q <= (head_beats_i != '0);
    end else if (last_beat) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (beat) begin
      cnt_q  <= cnt_inc;
    end
  end

endmodule

// File: rtl/wdpc_release_timer.sv
module wdpc_release_timer #(
  parameter int LIMIT = 1
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic busy_i,
  input  logic drdy_i,
  output logic hold_evt_o
);
  localparam int AGE_W = $clog2(LIMIT + 1) + 1;

  logic             busy_d_q;
  logic             armed_q;
  logic [AGE_W-1:0] age_q;
  logic             busy_fall;

  assign busy_fall  = busy_d_q && !busy_i;
  assign hold_evt_o = armed_q && drdy_i && (age_q == AGE_W'(LIMIT));

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      busy_d_q <= 1'b0;
      armed_q  <= 1'b0;
      age_q    <= '0;
    end else begin
      busy_d_q <= busy_i;
      if (busy_fall && drdy_i) begin
        armed_q <= 1'b1;
        age_q   <= AGE_W'(1);
      end else if (armed_q) begin
        if (!drdy_i || hold_evt_o) armed_q <= 1'b0;
        else                       age_q   <= age_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wr_data_phase_chk.sv
module wr_data_phase_chk #(
  parameter int QDEPTH     = 4,
  parameter int CNT_W      = 3,
  parameter int DBSY_LIMIT = 1,
  parameter int SBSY_LIMIT = 2
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       req_valid_i,
  input  logic [1:0] req_len_i,
  input  logic       trdy_i,
  input  logic       drdy_i,
  input  logic       dbsy_i,
  input  logic       sbsy_i,
  output logic       err_len_o,
  output logic       err_wdata_o,
  output logic       err_hold_o
);
  localparam int N_TIMERS = 2;

  wdpc_pkg::len_code_t head_code;
  wdpc_pkg::beats_t    head_beats;
  logic                q_empty;
  logic                pop;
  logic                phase_open;
  logic                len_evt, wd_evt;
  logic [N_TIMERS-1:0] busy_vec, hold_evt;
  logic                seen_q;

  assign head_beats = wdpc_pkg::beats_of(head_code);
  assign busy_vec   = {sbsy_i, dbsy_i};

  wdpc_len_fifo #(.DEPTH(QDEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .push_i      (req_valid_i),
    .push_code_i (req_len_i),
    .pop_i       (pop),
    .head_code_o (head_code),
    .empty_o     (q_empty)
  );

  wdpc_phase_track #(.CNT_W(CNT_W)) u_phase (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .trdy_i       (trdy_i),
    .drdy_i       (drdy_i),
    .dbsy_i       (dbsy_i),
    .q_empty_i    (q_empty),
    .head_beats_i (head_beats),
    .pop_o        (pop),
    .phase_open_o (phase_open),
    .len_evt_o    (len_evt),
    .wd_evt_o     (wd_evt)
  );

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_timer
    localparam int LIM = (g == 0) ? DBSY_LIMIT : SBSY_LIMIT;
    wdpc_release_timer #(.LIMIT(LIM)) u_tmr (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .busy_i     (busy_vec[g]),
      .drdy_i     (drdy_i),
      .hold_evt_o (hold_evt[g])
    );
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      seen_q      <= 1'b0;
      err_len_o   <= 1'b0;
      err_wdata_o <= 1'b0;
      err_hold_o  <= 1'b0;
    end else begin
      seen_q      <= seen_q || req_valid_i;
      err_len_o   <= seen_q && len_evt;
      err_wdata_o <= seen_q && wd_evt;
      err_hold_o  <= seen_q && (|hold_evt);
    end
  end

endmodule

// File: rtl/wr_data_phase_chk_sva.sv
module wr_data_phase_chk_sva (
  input logic clk_i,
  input logic rst_n_i,
  input logic trdy_i,
  input logic drdy_i,
  input logic dbsy_i,
  input logic err_len_o,
  input logic err_wdata_o,
  input logic err_hold_o,
  input logic seen_q,
  input logic phase_open
);
  // R1
  open_after_trdy_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(phase_open) |-> $past(trdy_i));

  // R2
  len_err_on_last_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    err_len_o |-> $past(drdy_i && !dbsy_i));

  // R3
  unsolicited_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (drdy_i && !phase_open && seen_q) |=> err_wdata_o);

  // R5
  hold_needs_drdy_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    err_hold_o |-> ($past(drdy_i) && $past(drdy_i, 2)));

  // R7
  len_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    err_len_o |=> !err_len_o);

  // R8
  quiet_before_req_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !seen_q |=> !(err_len_o || err_wdata_o || err_hold_o));
endmodule

bind wr_data_phase_chk wr_data_phase_chk_sva u_sva (.*);

// File: tb/wr_data_phase_chk_tb_top.sv
module wr_data_phase_chk_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, trdy = 1'b0, drdy = 1'b0, dbsy = 1'b0, sbsy = 1'b0;
  logic [1:0] req_len = 2'd0;
  logic err_len, err_wdata, err_hold;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wr_data_phase_chk dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .req_valid_i(req_valid), .req_len_i(req_len),
    .trdy_i(trdy), .drdy_i(drdy), .dbsy_i(dbsy), .sbsy_i(sbsy),
    .err_len_o(err_len), .err_wdata_o(err_wdata), .err_hold_o(err_hold)
  );

  // Behavioural reference model
  int  m_q[$];
  bit  m_open, m_seen;
  int  m_exp, m_cnt;
  bit  m_arm[2], m_prev[2];
  int  m_age[2];
  int  lim[2] = '{1, 2};
  bit  e_len, e_wd, e_hold;
  bit  ev_len, ev_wd, ev_hold, open0, room, tev, fall, bz;
  int  b;

  function automatic int len_to_beats(int code);
    if (code == 3) return 4;
    return code;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_open = 0; m_seen = 0; m_exp = 0; m_cnt = 0;
      for (int k = 0; k < 2; k++) begin m_arm[k] = 0; m_prev[k] = 0; m_age[k] = 0; end
      e_len = 0; e_wd = 0; e_hold = 0;
    end else begin
      ev_len = 0; ev_wd = 0; ev_hold = 0;
      open0 = m_open;
      room = (m_q.size() < 4);
      if (drdy) begin
        if (!open0) ev_wd = 1;
        else begin
          m_cnt = (m_cnt >= 7) ? 7 : m_cnt + 1;
          if (!dbsy) begin ev_len = (m_cnt != m_exp); m_open = 0; end
        end
      end
      if (trdy && !open0 && m_q.size() > 0) begin
        b = len_to_beats(m_q.pop_front());
        if (b > 0) begin m_open = 1; m_exp = b; m_cnt = 0; end
      end
      if (req_valid && room) m_q.push_back(int'(req_len));
      for (int k = 0; k < 2; k++) begin
        bz = (k == 0) ? dbsy : sbsy;
        fall = m_prev[k] && !bz;
        tev = m_arm[k] && drdy && (m_age[k] == lim[k]);
        if (tev) ev_hold = 1;
        if (fall && drdy) begin m_arm[k] = 1; m_age[k] = 1; end
        else if (m_arm[k]) begin
          if (!drdy || tev) m_arm[k] = 0;
          else m_age[k] = m_age[k] + 1;
        end
        m_prev[k] = bz;
      end
      e_len = m_seen && ev_len;
      e_wd = m_seen && ev_wd;
      e_hold = m_seen && ev_hold;
      m_seen = m_seen || req_valid;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int n_len = 0, n_wd = 0, n_hold = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(err_len == e_len, "R2 R7 err_len per cycle", err_len, e_len);
      check(err_wdata == e_wd, "R3 R4 err_wdata per cycle", err_wdata, e_wd);
      check(err_hold == e_hold, "R5 R6 err_hold per cycle", err_hold, e_hold);
      n_len += err_len; n_wd += err_wdata; n_hold += err_hold;
    end
  end

  task automatic step(input bit rv, input int ln, input bit tr, input bit dr,
                      input bit db, input bit sb);
    @(negedge clk);
    req_valid = rv; req_len = 2'(ln); trdy = tr; drdy = dr; dbsy = db; sbsy = sb;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  int s_len, s_wd, s_hold;
  task automatic snap();
    s_len = n_len; s_wd = n_wd; s_hold = n_hold;
  endtask

  task automatic totals(input string tag, input int el, input int ew, input int eh);
    idle(3);
    @(negedge clk);
    check(n_len - s_len == el, {tag, " len pulses"}, n_len - s_len, el);
    check(n_wd - s_wd == ew, {tag, " wdata pulses"}, n_wd - s_wd, ew);
    check(n_hold - s_hold == eh, {tag, " hold pulses"}, n_hold - s_hold, eh);
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    check(!err_len && !err_wdata && !err_hold, "R8 outputs low in reset",
          {err_len, err_wdata, err_hold}, 0);
    rst_n = 1'b1;
    idle(2);
    // R8: violations before any request stay silent
    snap();
    step(0, 0, 0, 1, 1, 0); step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 1, 0, 0);
    totals("R8 no report before first request", 0, 0, 0);
    // R1 R2: correct 4-beat write
    snap();
    step(1, 3, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0); step(0, 0, 0, 1, 1, 0); step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0, 0);
    totals("R1 R2 good 4-beat write", 0, 0, 0);
    // R2 R7: too few beats
    snap();
    step(1, 2, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 0); step(0, 0, 0, 1, 0, 0);
    totals("R2 R7 short write", 1, 0, 0);
    // R2: too many beats
    snap();
    step(1, 1, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0); step(0, 0, 0, 1, 1, 0); step(0, 0, 0, 1, 0, 0);
    totals("R2 long write", 1, 0, 0);
    // R3: unsolicited data
    snap();
    step(0, 0, 0, 1, 0, 0);
    totals("R3 unsolicited beat", 0, 1, 0);
    // R4: zero-length write with data
    snap();
    step(1, 0, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 0); step(0, 0, 0, 1, 0, 0);
    totals("R4 zero-length data", 0, 1, 0);
    // R5: data-ready held after data-busy release
    snap();
    step(1, 2, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0); step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 1, 0, 0);
    totals("R5 data-busy hold", 0, 1, 1);
    // R6: data-ready held two clocks after snoop-busy release
    snap();
    step(1, 3, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 1, 1, 1); step(0, 0, 0, 1, 1, 0); step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0, 0);
    totals("R6 snoop-busy hold", 0, 0, 1);
    // R6: release within the snoop window
    snap();
    step(1, 3, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 1);
    step(0, 0, 0, 1, 1, 1); step(0, 0, 0, 1, 1, 1); step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0, 0);
    totals("R6 snoop release in time", 0, 0, 0);
    // R9 R1: trdy during an open phase is ignored, queue order kept
    snap();
    step(1, 3, 0, 0, 0, 0); step(1, 2, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0); step(0, 0, 1, 1, 1, 0); step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0); step(0, 0, 0, 1, 1, 0); step(0, 0, 0, 1, 0, 0);
    totals("R9 R1 trdy ignored while open", 0, 0, 0);
    // R9: trdy with an empty queue opens nothing
    snap();
    step(0, 0, 1, 0, 0, 0); step(0, 0, 0, 1, 0, 0);
    totals("R9 trdy on empty queue", 0, 1, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule